// File: doc/BRIEF.md
# Framebuffer Display Transfer Engine

The engine copies a rectangular image from a source buffer in memory to a destination buffer. A single trigger write starts it. On the way, each pixel is decoded from its source format, can be averaged with its neighbours to halve the image, and is re-encoded in the destination format. Both buffers are laid out either row-linear or in 8x8 tiles with bit-interleaved (Morton) order inside each tile. The source row index can be mirrored so that the picture comes out upside down.

Configuration comes in on plain input pins. The engine captures them in the cycle of the trigger. Memory is reached through two byte-wide request/acknowledge ports, one for reads and one for writes. A one-cycle completion pulse reports the end of each transfer. The engine walks the output image in raster order. For each output pixel it reads the bytes of one, two or four consecutive source pixels, averages them, and writes the resulting bytes.

Top module: `fb_xfer_engine`

## Requirements
- R1: After reset, `xfer_busy`, `done_irq`, `rd_req` and `wr_req` are all low. While `xfer_busy` is low, no memory request is raised.
- R2: A transfer starts when `trig_we` is high with `trig_val` = 1 while the engine is idle. `xfer_busy` is high from the next cycle until the transfer ends. `done_irq` is high for exactly one cycle, in the last busy cycle, and then `xfer_busy` clears. A trigger seen while busy, or with `trig_val` = 0, is ignored.
- R3: `cfg_scale` selects the scaling. 0 means none. 1 (and 3) means X-only: the output width is `cfg_out_w >> 1`. 2 means XY: width and height are both shifted right by 1. Output pixel (x,y) takes its source coordinate as x<<1 in X when X is scaled, and as y<<1 in Y when Y is scaled.
- R4: In X-only mode each output channel is the truncated mean of the addressed source pixel and the pixel that follows it in memory. In XY mode it is the truncated mean of the addressed pixel and the three pixels that follow it in memory (sum divided by 4).
- R5: If `cfg_tiled_out` = 1 and `cfg_scale` != 0 at the trigger, the transfer is refused. The engine stays idle, writes nothing and raises no `done_irq`.
- R6: A tiled pixel lies at byte offset bpp*(64*(x>>3) + M + 8*(y>>3)*W). W is the buffer width in pixels. M is the 6-bit value {y[2],x[2],y[1],x[1],y[0],x[0]}. A linear pixel lies at bpp*(x + y*W). The source width is `cfg_in_w`; the destination width is the output width.
- R7: With `cfg_no_swizzle` = 0, tiled output selects a linear source and a tiled destination, and untiled output selects a tiled source and a linear destination. With `cfg_no_swizzle` = 1, both buffers are linear when `cfg_tiled_out` = 1 and both are tiled otherwise.
- R8: Source format codes decode bytes assembled little-endian into a word w:
  - 0 RGBA8 (4 bytes): R=w[31:24], G=w[23:16], B=w[15:8], A=w[7:0].
  - 1 RGB8 (3 bytes): R=w[23:16], G=w[15:8], B=w[7:0], A=255.
  - 2 RGB565 (2 bytes): R=w[15:11], G=w[10:5], B=w[4:0], A=255.
  - 3 RGB5A1 (2 bytes): R=w[15:11], G=w[10:6], B=w[5:1], A = 255 when w[0] is 1, else 0.
  - 4 RGBA4 (2 bytes): R=w[15:12], G=w[11:8], B=w[7:4], A=w[3:0].
  - Narrow channels widen by repeating their top bits.
  - Codes 5 to 7 take 2 bytes and decode as all-zero colour.
- R9: Destination bytes use the same layouts and byte counts as R8. Each channel keeps its top bits, and A in RGB5A1 is A[7]. RGB8 and the 16-bit formats drop A. Codes 5 to 7 write two zero bytes.
- R10: When `cfg_flip` = 1, the source row is `cfg_in_h`-1 minus the (scaled) output row.
- R11: A read or write request that is not acknowledged stays raised in the next cycle, with its address (and write data) unchanged. A read and a write are never requested in the same cycle.
- R12: If the output width or height comes out as zero, the transfer completes with one `done_irq` and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_we | input | 1 | Trigger register write strobe |
| trig_val | input | 1 | Trigger bit value being written |
| cfg_src_addr | input | ADDR_W | Source buffer byte address |
| cfg_dst_addr | input | ADDR_W | Destination buffer byte address |
| cfg_in_w | input | DIM_W | Source width in pixels |
| cfg_in_h | input | DIM_W | Source height in pixels |
| cfg_out_w | input | DIM_W | Output width before scaling |
| cfg_out_h | input | DIM_W | Output height before scaling |
| cfg_in_fmt | input | 3 | Source pixel format code |
| cfg_out_fmt | input | 3 | Destination pixel format code |
| cfg_scale | input | 2 | Scaling mode |
| cfg_tiled_out | input | 1 | Tiled output select |
| cfg_no_swizzle | input | 1 | Same layout on both sides |
| cfg_flip | input | 1 | Vertical mirror |
| xfer_busy | output | 1 | Transfer in progress (trigger readback) |
| done_irq | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ack | input | 1 | Read accepted, data valid |
| rd_data | input | 8 | Read byte, valid with rd_ack |
| wr_req | output | 1 | Byte write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8 | Write byte |
| wr_ack | input | 1 | Write accepted |

## Verification
The bench builds the engine with ADDR_W = 12 and DIM_W = 8. It places the source at byte 0 and the destination at byte 2048 of a 4 KiB model memory. Images of 8 or 16 pixels per side cover several things:
- rows spanning two tiles, which exercises the coarse-X term of the tiled offset;
- two tile rows, which exercises the coarse-Y stride;
- flipped rows reaching the last source line.

Acknowledge rates between half and full hold requests over many cycles. Random runs over every format pair and layout mix are checked byte by byte against a reference model. Directed runs cover refusal, zero size and retriggering.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

  localparam logic [2:0] FMT_RGBA8  = 3'd0;
  localparam logic [2:0] FMT_RGB8   = 3'd1;
  localparam logic [2:0] FMT_RGB565 = 3'd2;
  localparam logic [2:0] FMT_RGB5A1 = 3'd3;
  localparam logic [2:0] FMT_RGBA4  = 3'd4;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] a;
  } rgba_t;

  function automatic logic [2:0] fmt_bytes(input logic [2:0] f);
    case (f)
      FMT_RGBA8: return 3'd4;
      FMT_RGB8:  return 3'd3;
      default:   return 3'd2;
    endcase
  endfunction

  function automatic rgba_t fmt_decode(input logic [2:0] f, input logic [31:0] w);
    rgba_t c;
    case (f)
      FMT_RGBA8:  c = w;
      FMT_RGB8:   c = {w[23:16], w[15:8], w[7:0], 8'hFF};
      FMT_RGB565: c = {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2], 8'hFF};
      FMT_RGB5A1: c = {w[15:11], w[15:13], w[10:6], w[10:8], w[5:1], w[5:3], {8{w[0]}}};
      FMT_RGBA4:  c = {w[15:12], w[15:12], w[11:8], w[11:8], w[7:4], w[7:4], w[3:0], w[3:0]};
      default:    c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [31:0] fmt_encode(input logic [2:0] f, input rgba_t c);
    case (f)
      FMT_RGBA8:  return {c.r, c.g, c.b, c.a};
      FMT_RGB8:   return {8'h00, c.r, c.g, c.b};
      FMT_RGB565: return {16'h0, c.r[7:3], c.g[7:2], c.b[7:3]};
      FMT_RGB5A1: return {16'h0, c.r[7:3], c.g[7:3], c.b[7:3], c.a[7]};
      FMT_RGBA4:  return {16'h0, c.r[7:4], c.g[7:4], c.b[7:4], c.a[7:4]};
      default:    return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/fbx_addr_gen.sv
// Byte offset of pixel (x,y) in a buffer that is either row-linear or
// made of 8x8 tiles with bit-interleaved order inside each tile.
module fbx_addr_gen #(
  parameter int DIM_W = 10,
  parameter int OFF_W = 2 * DIM_W + 3
) (
  input  logic [DIM_W-1:0] x,
  input  logic [DIM_W-1:0] y,
  input  logic [DIM_W-1:0] width,
  input  logic [2:0]       bpp,
  input  logic             tiled,
  output logic [OFF_W-1:0] off
);
  logic [OFF_W-1:0] xw, yw, ww, mort, pix;

  always_comb begin
    xw   = OFF_W'(x);
    yw   = OFF_W'(y);
    ww   = OFF_W'(width);
    mort = OFF_W'({y[2], x[2], y[1], x[1], y[0], x[0]});
    if (tiled) pix = ((xw >> 3) << 6) + mort + ((yw >> 3) << 3) * ww;
    else       pix = xw + yw * ww;
    off = pix * OFF_W'(bpp);
  end
endmodule

// File: rtl/fbx_pixel_path.sv
// Decodes source words, accumulates per channel, averages by shift and
// re-encodes for the destination.
module fbx_pixel_path
  import fbx_pkg::*;
#(
  parameter int ACC_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        add,
  input  logic [2:0]  fmt_in,
  input  logic [31:0] word_in,
  input  logic [1:0]  shift,
  input  logic [2:0]  fmt_out,
  output logic [31:0] enc_word
);
  rgba_t                  dec, avg;
  logic [3:0][ACC_W-1:0]  acc_q, acc_n;

  assign dec = fmt_decode(fmt_in, word_in);

  for (genvar ch = 0; ch < 4; ch++) begin : g_chan
    always_comb begin
      if (clr)      acc_n[ch] = '0;
      else if (add) acc_n[ch] = acc_q[ch] + ACC_W'(dec[8*ch +: 8]);
      else          acc_n[ch] = acc_q[ch];
    end
    assign avg[8*ch +: 8] = 8'(acc_q[ch] >> shift);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr || add) acc_q <= acc_n;
  end

  assign enc_word = fmt_encode(fmt_out, avg);
endmodule

// File: rtl/fb_xfer_engine.sv
module fb_xfer_engine
  import fbx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic              trig_val,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [DIM_W-1:0]  cfg_in_w,
  input  logic [DIM_W-1:0]  cfg_in_h,
  input  logic [DIM_W-1:0]  cfg_out_w,
  input  logic [DIM_W-1:0]  cfg_out_h,
  input  logic [2:0]        cfg_in_fmt,
  input  logic [2:0]        cfg_out_fmt,
  input  logic [1:0]        cfg_scale,
  input  logic              cfg_tiled_out,
  input  logic              cfg_no_swizzle,
  input  logic              cfg_flip,
  output logic              xfer_busy,
  output logic              done_irq,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ack
);
  localparam int OFF_W = 2 * DIM_W + 3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} state_t;

  state_t            state_q, state_n;
  logic [DIM_W-1:0]  x_q, x_n, y_q, y_n;
  logic [1:0]        pb_q, pb_n, pk_q, pk_n;
  logic [31:0]       wbuf_q, wbuf_n, word_mrg, enc_word;
  logic              acc_clr, acc_add;

  // captured configuration
  logic [ADDR_W-1:0] src_base_q, dst_base_q;
  logic [DIM_W-1:0]  in_w_q, in_h_q, out_w_q, out_h_q;
  logic [2:0]        fin_q, fout_q;
  logic              sx_q, sy_q, flip_q, src_tl_q, dst_tl_q;

  // trigger decode
  logic              sx_in, sy_in, start, empty;
  logic [DIM_W-1:0]  ow_in, oh_in;

  assign sx_in = (cfg_scale != 2'd0);
  assign sy_in = (cfg_scale == 2'd2);
  assign ow_in = cfg_out_w >> sx_in;
  assign oh_in = cfg_out_h >> sy_in;
  assign start = trig_we && trig_val && (state_q == S_IDLE) && !(cfg_tiled_out && sx_in);
  assign empty = (ow_in == '0) || (oh_in == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base_q <= '0; dst_base_q <= '0;
      in_w_q <= '0; in_h_q <= '0; out_w_q <= '0; out_h_q <= '0;
      fin_q <= '0; fout_q <= '0;
      sx_q <= 1'b0; sy_q <= 1'b0; flip_q <= 1'b0; src_tl_q <= 1'b0; dst_tl_q <= 1'b0;
    end else if (start) begin
      src_base_q <= cfg_src_addr; dst_base_q <= cfg_dst_addr;
      in_w_q <= cfg_in_w; in_h_q <= cfg_in_h; out_w_q <= ow_in; out_h_q <= oh_in;
      fin_q <= cfg_in_fmt; fout_q <= cfg_out_fmt;
      sx_q <= sx_in; sy_q <= sy_in; flip_q <= cfg_flip;
      src_tl_q <= !cfg_tiled_out;
      dst_tl_q <= cfg_no_swizzle ? !cfg_tiled_out : cfg_tiled_out;
    end
  end

  // source coordinate and per-pixel sizes
  logic [2:0]       sbpp, dbpp;
  logic [1:0]       pk_last;
  logic [DIM_W-1:0] ix, iy0, iy;
  logic [OFF_W-1:0] src_off, dst_off;

  assign sbpp    = fmt_bytes(fin_q);
  assign dbpp    = fmt_bytes(fout_q);
  assign pk_last = sy_q ? 2'd3 : (sx_q ? 2'd1 : 2'd0);
  assign ix      = x_q << sx_q;
  assign iy0     = y_q << sy_q;
  assign iy      = flip_q ? (in_h_q - DIM_W'(1) - iy0) : iy0;

  fbx_addr_gen #(.DIM_W(DIM_W), .OFF_W(OFF_W)) u_src_ag (
    .x(ix), .y(iy), .width(in_w_q), .bpp(sbpp), .tiled(src_tl_q), .off(src_off)
  );
  fbx_addr_gen #(.DIM_W(DIM_W), .OFF_W(OFF_W)) u_dst_ag (
    .x(x_q), .y(y_q), .width(out_w_q), .bpp(dbpp), .tiled(dst_tl_q), .off(dst_off)
  );

  assign rd_addr = src_base_q + ADDR_W'(src_off) + ADDR_W'(pk_q) * ADDR_W'(sbpp) + ADDR_W'(pb_q);
  assign wr_addr = dst_base_q + ADDR_W'(dst_off) + ADDR_W'(pb_q);
  assign wr_data = 8'(enc_word >> {pb_q, 3'b000});

  always_comb begin
    word_mrg = wbuf_q;
    for (int b = 0; b < 4; b++)
      if (pb_q == 2'(b)) word_mrg[8*b +: 8] = rd_data;
  end

  fbx_pixel_path u_pix (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
    .fmt_in(fin_q), .word_in(word_mrg), .shift({sy_q, sx_q & ~sy_q}),
    .fmt_out(fout_q), .enc_word(enc_word)
  );

  // next-state process
  always_comb begin
    state_n = state_q; x_n = x_q; y_n = y_q; pb_n = pb_q; pk_n = pk_q;
    wbuf_n = wbuf_q; acc_clr = 1'b0; acc_add = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        x_n = '0; y_n = '0; pb_n = '0; pk_n = '0; acc_clr = 1'b1;
        state_n = empty ? S_DONE : S_RD;
      end
      S_RD: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          wbuf_n = word_mrg;
          if (pb_q == 2'(sbpp - 3'd1)) begin
            pb_n = '0; acc_add = 1'b1;
            if (pk_q == pk_last) begin pk_n = '0; state_n = S_WR; end
            else pk_n = pk_q + 2'd1;
          end else pb_n = pb_q + 2'd1;
        end
      end
      S_WR: begin
        wr_req = 1'b1;
        if (wr_ack) begin
          if (pb_q == 2'(dbpp - 3'd1)) begin
            pb_n = '0; acc_clr = 1'b1; state_n = S_RD;
            if (x_q == out_w_q - DIM_W'(1)) begin
              x_n = '0;
              if (y_q == out_h_q - DIM_W'(1)) state_n = S_DONE;
              else y_n = y_q + DIM_W'(1);
            end else x_n = x_q + DIM_W'(1);
          end else pb_n = pb_q + 2'd1;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; x_q <= '0; y_q <= '0; pb_q <= '0; pk_q <= '0; wbuf_q <= '0;
    end else begin
      state_q <= state_n; x_q <= x_n; y_q <= y_n; pb_q <= pb_n; pk_q <= pk_n; wbuf_q <= wbuf_n;
    end
  end

  assign xfer_busy = (state_q != S_IDLE);
  assign done_irq  = (state_q == S_DONE);
endmodule

// File: rtl/fbx_checker.sv
module fbx_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_we,
  input logic              trig_val,
  input logic              cfg_tiled_out,
  input logic [1:0]        cfg_scale,
  input logic              xfer_busy,
  input logic              done_irq,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> (!rd_req && !wr_req));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_val && !xfer_busy && !(cfg_tiled_out && cfg_scale != 2'd0)) |=> xfer_busy);

  assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> (!done_irq && !xfer_busy));

  assert_irq_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> xfer_busy);

  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_val && !xfer_busy && cfg_tiled_out && cfg_scale != 2'd0) |=> !xfer_busy);

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
endmodule

bind fb_xfer_engine fbx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_val(trig_val),
  .cfg_tiled_out(cfg_tiled_out), .cfg_scale(cfg_scale),
  .xfer_busy(xfer_busy), .done_irq(done_irq),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/fb_xfer_engine_tb.sv
module fb_xfer_engine_tb;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int DST = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_we = 1'b0, trig_val = 1'b0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = AW'(DST);
  logic [DW-1:0] cfg_in_w = '0, cfg_in_h = '0, cfg_out_w = '0, cfg_out_h = '0;
  logic [2:0] cfg_in_fmt = '0, cfg_out_fmt = '0;
  logic [1:0] cfg_scale = '0;
  logic cfg_tiled_out = 1'b0, cfg_no_swizzle = 1'b0, cfg_flip = 1'b0;
  logic xfer_busy, done_irq, rd_req, rd_ack, wr_req, wr_ack;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic rd_gate = 1'b1, wr_gate = 1'b1;
  int ack_pct = 100;

  logic [7:0] mem [4096];
  logic [7:0] exp_mem [4096];
  int total = 0, bad = 0;
  int c_iw, c_ih, c_ow, c_oh, c_fi, c_fo, c_sc, c_tl, c_ns, c_fl;

  always #2 clk = ~clk;

  fb_xfer_engine #(.ADDR_W(AW), .DIM_W(DW)) u_dut (.*);

  assign rd_ack  = rd_req & rd_gate;
  assign wr_ack  = wr_req & wr_gate;
  assign rd_data = mem[rd_addr];

  always @(posedge clk) if (wr_req && wr_ack) mem[wr_addr] <= wr_data;
  always @(negedge clk) begin
    rd_gate <= ($urandom % 100) < ack_pct;
    wr_gate <= ($urandom % 100) < ack_pct;
  end

  initial begin
    #(4 * 190000);
    bad++; total++;
    $display("FAIL watchdog: run did not end actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int bpp_f(input int f);
    return (f == 0) ? 4 : (f == 1) ? 3 : 2;
  endfunction

  // returns {r,g,b,a}
  function automatic logic [31:0] dec_f(input int f, input logic [31:0] w);
    case (f)
      0: return w;
      1: return {w[23:0], 8'hFF};
      2: return {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2], 8'hFF};
      3: return {w[15:11], w[15:13], w[10:6], w[10:8], w[5:1], w[5:3], (w[0] ? 8'hFF : 8'h00)};
      4: return {w[15:12], w[15:12], w[11:8], w[11:8], w[7:4], w[7:4], w[3:0], w[3:0]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] enc_f(input int f, input logic [31:0] c);
    case (f)
      0: return c;
      1: return {8'h0, c[31:8]};
      2: return {16'h0, c[31:27], c[23:18], c[15:11]};
      3: return {16'h0, c[31:27], c[23:19], c[15:11], c[7]};
      4: return {16'h0, c[31:28], c[23:20], c[15:12], c[7:4]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic int pix_off(input int x, input int y, input int w, input int bpp, input int tiled);
    int m;
    m = (x & 1) | ((y & 1) << 1) | ((x & 2) << 1) | ((y & 2) << 2) | ((x & 4) << 2) | ((y & 4) << 3);
    if (tiled != 0) return ((x / 8) * 64 + m + (y / 8) * 8 * w) * bpp;
    return (x + y * w) * bpp;
  endfunction

  // Reference model: fills exp_mem from mem and the c_* configuration.
  task automatic build_expected();
    int sx, sy, ow, oh, n, sb, db, st, dt, sh;
    for (int i = 0; i < 4096; i++) exp_mem[i] = mem[i];
    sx = (c_sc != 0); sy = (c_sc == 2);
    ow = c_ow >> sx; oh = c_oh >> sy;
    n = sy ? 4 : (sx ? 2 : 1); sh = sy ? 2 : sx;
    sb = bpp_f(c_fi); db = bpp_f(c_fo);
    st = !c_tl; dt = c_ns ? !c_tl : c_tl;
    for (int y = 0; y < oh; y++) begin
      for (int x = 0; x < ow; x++) begin
        int ix, iy, so, doff;
        int sum[4];
        logic [31:0] cavg, enc;
        ix = x << sx; iy = y << sy;
        if (c_fl != 0) iy = c_ih - 1 - iy;
        so = pix_off(ix, iy, c_iw, sb, st);
        for (int c = 0; c < 4; c++) sum[c] = 0;
        for (int k = 0; k < n; k++) begin
          logic [31:0] w, d;
          w = '0;
          for (int b = 0; b < sb; b++) w[8*b +: 8] = mem[so + k * sb + b];
          d = dec_f(c_fi, w);
          for (int c = 0; c < 4; c++) sum[c] += int'(d[8*c +: 8]);
        end
        for (int c = 0; c < 4; c++) cavg[8*c +: 8] = 8'(sum[c] >> sh);
        enc = enc_f(c_fo, cavg);
        doff = DST + pix_off(x, y, ow, db, dt);
        for (int b = 0; b < db; b++) exp_mem[doff + b] = enc[8*b +: 8];
      end
    end
  endtask

  task automatic drive_cfg();
    cfg_in_w = DW'(c_iw); cfg_in_h = DW'(c_ih); cfg_out_w = DW'(c_ow); cfg_out_h = DW'(c_oh);
    cfg_in_fmt = 3'(c_fi); cfg_out_fmt = 3'(c_fo); cfg_scale = 2'(c_sc);
    cfg_tiled_out = c_tl[0]; cfg_no_swizzle = c_ns[0]; cfg_flip = c_fl[0];
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
  endtask

  // One transfer; compares the whole destination region and the pulse count.
  task automatic run_xfer(input string tag, input bit retrig);
    int irqs, cyc, wrs, miss;
    build_expected();
    @(negedge clk); drive_cfg(); trig_we = 1'b1; trig_val = 1'b1;
    @(negedge clk); trig_we = 1'b0;
    check(xfer_busy === 1'b1, "R2", {tag, " busy after trigger"}, int'(xfer_busy), 1);
    irqs = 0; cyc = 0; wrs = 0;
    while (cyc < 30000) begin
      if (retrig && cyc == 3) begin
        cfg_tiled_out = ~cfg_tiled_out; cfg_scale = 2'd0; trig_we = 1'b1;
      end else if (retrig && cyc == 4) begin
        trig_we = 1'b0; drive_cfg();
      end
      if (done_irq) irqs++;
      if (wr_req) wrs++;
      if (!xfer_busy) break;
      @(negedge clk); cyc++;
    end
    check(irqs == 1, "R2", {tag, " completion pulses"}, irqs, 1);
    miss = 0;
    for (int i = DST; i < 4096; i++) if (mem[i] !== exp_mem[i]) miss++;
    // R3 R4 R6 R7 R8 R9 R10 R11: destination image equals the model byte for byte
    check(miss == 0, "R3/R4/R6/R7/R8/R9/R10/R11", {tag, " mismatched bytes"}, miss, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill_mem();
    repeat (3) @(negedge clk);
    check(!xfer_busy && !done_irq && !rd_req && !wr_req, "R1", "outputs in reset",
          int'({xfer_busy, done_irq, rd_req, wr_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!xfer_busy && !done_irq && !rd_req && !wr_req, "R1", "idle after reset",
          int'({xfer_busy, done_irq, rd_req, wr_req}), 0);

    // R2: trigger written with value 0 does nothing
    c_iw = 8; c_ih = 8; c_ow = 8; c_oh = 8; c_fi = 0; c_fo = 0; c_sc = 0; c_tl = 0; c_ns = 0; c_fl = 0;
    drive_cfg(); trig_we = 1'b1; trig_val = 1'b0;
    @(negedge clk); trig_we = 1'b0;
    @(negedge clk);
    check(!xfer_busy, "R2", "zero trigger value ignored", int'(xfer_busy), 0);

    // R5: tiled output with scaling is refused
    begin
      int seen, miss;
      for (int i = DST; i < 4096; i++) exp_mem[i] = mem[i];
      c_tl = 1; c_sc = 2; drive_cfg(); trig_we = 1'b1; trig_val = 1'b1;
      @(negedge clk); trig_we = 1'b0;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        if (xfer_busy || done_irq || wr_req) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R5", "refused transfer activity", seen, 0);
      miss = 0;
      for (int i = DST; i < 4096; i++) if (mem[i] !== exp_mem[i]) miss++;
      check(miss == 0, "R5", "refused transfer wrote bytes", miss, 0);
    end

    // R12: X-only scaling of width 1 gives an empty output
    begin
      int irqs, acc;
      c_tl = 0; c_sc = 1; c_ow = 1; drive_cfg(); trig_we = 1'b1;
      @(negedge clk); trig_we = 1'b0;
      irqs = 0; acc = 0;
      for (int i = 0; i < 10; i++) begin
        if (done_irq) irqs++;
        if (rd_req || wr_req) acc++;
        @(negedge clk);
      end
      check(irqs == 1, "R12", "empty transfer pulses", irqs, 1);
      check(acc == 0, "R12", "empty transfer memory accesses", acc, 0);
      check(!xfer_busy, "R12", "empty transfer back to idle", int'(xfer_busy), 0);
    end

    // Directed: retrigger while busy (R2) with slow memory (R11)
    ack_pct = 40;
    c_iw = 16; c_ih = 8; c_ow = 16; c_oh = 8; c_fi = 0; c_fo = 2; c_sc = 0; c_tl = 0; c_ns = 0; c_fl = 1;
    run_xfer("retrigger", 1'b1);

    // Directed: XY averaging for every source format (R4, R8)
    ack_pct = 100;
    for (int f = 0; f < 6; f++) begin
      fill_mem();
      c_iw = 8; c_ih = 8; c_ow = 8; c_oh = 8; c_fi = f; c_fo = 0; c_sc = 2; c_tl = 0; c_ns = 0; c_fl = 0;
      run_xfer($sformatf("xy fmt%0d", f), 1'b0);
    end

    // Random transfers
    for (int t = 0; t < 16; t++) begin
      fill_mem();
      ack_pct = 50 + int'($urandom % 51);
      c_iw = ($urandom % 2) ? 16 : 8; c_ih = ($urandom % 2) ? 16 : 8;
      if (c_iw == 16 && c_ih == 16) c_ih = 8;
      c_ow = c_iw; c_oh = c_ih;
      c_fi = int'($urandom % 7); c_fo = int'($urandom % 7);
      c_tl = int'($urandom % 2); c_ns = int'($urandom % 2); c_fl = int'($urandom % 2);
      c_sc = c_tl ? 0 : int'($urandom % 4);
      run_xfer($sformatf("random %0d", t), 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule